// File: doc/BRIEF.md
# Multi-channel gamma lookup table

This block is the gamma correction stage of a compositor that drives three output channels. One shared table memory holds a separate 8-bit lookup for the red, green and blue components of every channel. Software fills the table through a register port made of two registers. The first holds an address and an auto-increment flag. Each write to the second stores one table entry. A full channel therefore loads with one address write followed by a burst of data writes.

Each pixel arrives with a channel tag and a valid flag. If gamma is enabled for that channel, each colour component is replaced by its table entry. Otherwise the pixel passes through unchanged, which gives the same result as a linear table. Output appears a fixed two cycles later in both modes.

When gamma is off on every channel at once, the table memory is treated as powered down. All its entries become invalid and read as zero until software writes them again.

Top module: `gamma_lut`

## Requirements
- R1: After reset, pixValidOut is 0, the address register is 0 with auto-increment clear, and every table entry is invalid: a lookup returns 0 for each component.
- R2: Table entry addresses follow channel*768 + plane*256 + value, with plane 0 = red, 1 = green and 2 = blue. Pixels are packed red in pixIn[23:16], green in [15:8] and blue in [7:0], and pixOut uses the same packing.
- R3: With auto-increment set, each data write stores its byte at the current address and then advances the address by one.
- R4: With auto-increment clear, data writes all go to the same address, so a later write overwrites an earlier one.
- R5: With auto-increment set, a data write at address 2303 (the last entry of channel 2) moves the address to 0.
- R6: A pixel whose channel has its chEnable bit clear, or whose tag is 3, leaves with pixOut equal to pixIn.
- R7: A pixel presented before clock edge k appears on pixValidOut, pixChOut and pixOut after edge k+1 and not earlier, in both lookup and bypass mode.
- R8: A cycle with chEnable equal to 0 invalidates every entry. After that, a lookup of an entry returns 0 until that entry is written again.
- R9: While chEnable is 0, data writes store nothing, but the address still advances when auto-increment is set.
- R10: A register write with regSel=0 loads the address from regWdata[11:0] and the auto-increment flag from regWdata[15]. A write with regSel=1 is a data write of regWdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the address register, 1 selects the data register |
| regWdata | input | 16 | Register write data |
| chEnable | input | 3 | Gamma enable, one bit per channel |
| pixValidIn | input | 1 | Input pixel valid |
| pixChIn | input | 2 | Input pixel channel tag |
| pixIn | input | 24 | Input pixel, red, green and blue |
| pixValidOut | output | 1 | Output pixel valid |
| pixChOut | output | 2 | Output pixel channel tag |
| pixOut | output | 24 | Corrected or bypassed pixel |

## Verification
A wrong address counter is not visible at any port directly. It shows up later, when a lookup of a shifted entry returns a neighbour's value. For this reason the table is loaded with a value that depends on the address, so that any misplaced entry shows up in the first pixel that reads it. A missed or extra invalidation shows up as a zero, or a stale non-zero value, on the first lookup after gamma is enabled again. A pipeline fault shows up two cycles after the pixel goes in, as a valid flag that is early, late or missing.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              invalidate;
  } gammaCtrlT;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ENTRIES = 256,
  parameter int REG_W   = 16,
  parameter int INC_BIT = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [REG_W-1:0]   regWdata,
  input  logic [NUM_CH-1:0]  chEnable,
  output gammaCtrlT          ctrlO
);
  localparam int TOTAL = NUM_CH * 3 * ENTRIES;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

  logic [ADDR_W-1:0] addr;
  logic              autoInc;
  logic              addrWr;
  logic              dataWr;
  logic              allOff;

  assign addrWr = regWrEn && !regSel;
  assign dataWr = regWrEn && regSel;
  assign allOff = (chEnable == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      autoInc <= 1'b0;
    end else if (addrWr) begin
      addr    <= regWdata[ADDR_W-1:0];
      autoInc <= regWdata[INC_BIT];
    end else if (dataWr && autoInc) begin
      addr <= (addr >= LAST) ? '0 : addr + 1'b1;
    end
  end

  always_comb begin
    ctrlO.wrEn       = dataWr && !allOff && (addr <= LAST);
    ctrlO.wrAddr     = addr;
    ctrlO.wrData     = regWdata[DATA_W-1:0];
    ctrlO.invalidate = allOff;
  end

  p_autoinc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && autoInc && addr < LAST) |=> (addr == $past(addr) + 1'b1));

  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !autoInc) |=> $stable(addr));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && autoInc && addr == LAST) |=> (addr == '0));
endmodule

// File: rtl/gamma_lut_datapath.sv
module gamma_lut_datapath
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ENTRIES = 256,
  parameter int CH_W    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gammaCtrlT             ctrlI,
  input  logic [NUM_CH-1:0]     chEnable,
  input  logic                  pixValidIn,
  input  logic [CH_W-1:0]       pixChIn,
  input  logic [3*DATA_W-1:0]   pixIn,
  output logic                  pixValidOut,
  output logic [CH_W-1:0]       pixChOut,
  output logic [3*DATA_W-1:0]   pixOut
);
  localparam int TOTAL  = NUM_CH * 3 * ENTRIES;
  localparam int PLANES = 3;

  logic [DATA_W-1:0] tableMem [TOTAL];
  logic [TOTAL-1:0]  entryValid;

  always_ff @(posedge clk) begin
    if (ctrlI.wrEn) tableMem[ctrlI.wrAddr] <= ctrlI.wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlI.invalidate) entryValid <= '0;
    else if (ctrlI.wrEn) entryValid[ctrlI.wrAddr] <= 1'b1;
  end

  logic chInRange;
  logic useLut;
  assign chInRange = (int'(pixChIn) < NUM_CH);
  always_comb begin
    useLut = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (int'(pixChIn) == c) useLut = chEnable[c];
  end

  logic [3*DATA_W-1:0] lookNow;
  logic [3*DATA_W-1:0] s1Look;
  logic [3*DATA_W-1:0] s1Pix;
  logic                s1Valid;
  logic                s1Bypass;
  logic [CH_W-1:0]     s1Ch;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    localparam int LO = (PLANES - 1 - p) * DATA_W;
    logic [ADDR_W-1:0] idx;
    assign idx = ADDR_W'(int'(pixChIn) * (3 * ENTRIES) + p * ENTRIES
                         + int'(pixIn[LO +: DATA_W]));
    assign lookNow[LO +: DATA_W] =
      (chInRange && entryValid[idx]) ? tableMem[idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid     <= 1'b0;
      pixValidOut <= 1'b0;
    end else begin
      s1Valid     <= pixValidIn;
      pixValidOut <= s1Valid;
    end
    s1Pix    <= pixIn;
    s1Ch     <= pixChIn;
    s1Look   <= lookNow;
    s1Bypass <= !(chInRange && useLut);
    pixChOut <= s1Ch;
    pixOut   <= s1Bypass ? s1Pix : s1Look;
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixValidIn |-> ##2 (pixValidOut && pixChOut == $past(pixChIn, 2)));

  p_no_early_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!pixValidIn && !s1Valid) |=> ##1 !pixValidOut);

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValidIn && !(chInRange && useLut)) |-> ##2 (pixOut == $past(pixIn, 2)));
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ENTRIES = 256,
  parameter int CH_W    = 2,
  parameter int REG_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regSel,
  input  logic [REG_W-1:0]      regWdata,
  input  logic [NUM_CH-1:0]     chEnable,
  input  logic                  pixValidIn,
  input  logic [CH_W-1:0]       pixChIn,
  input  logic [3*DATA_W-1:0]   pixIn,
  output logic                  pixValidOut,
  output logic [CH_W-1:0]       pixChOut,
  output logic [3*DATA_W-1:0]   pixOut
);
  gammaCtrlT ctrlBus;

  gamma_lut_ctrl #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .REG_W(REG_W), .INC_BIT(REG_W-1)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWdata(regWdata), .chEnable(chEnable), .ctrlO(ctrlBus)
  );

  gamma_lut_datapath #(.NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .CH_W(CH_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrlI(ctrlBus), .chEnable(chEnable),
    .pixValidIn(pixValidIn), .pixChIn(pixChIn), .pixIn(pixIn),
    .pixValidOut(pixValidOut), .pixChOut(pixChOut), .pixOut(pixOut)
  );
endmodule

// File: tb/gamma_lut_tb_top.sv
module gamma_lut_tb_top;
  localparam int TOTAL = 2304;
  localparam int NVEC  = 8;
  // {enable[2:0], channel[1:0], pixel[23:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {3'b111, 2'd0, 24'h000000}, {3'b111, 2'd0, 24'hFF80FF},
    {3'b111, 2'd1, 24'h123456}, {3'b111, 2'd2, 24'hABCDEF},
    {3'b101, 2'd1, 24'h0F1E2D}, {3'b101, 2'd2, 24'h7F7F7F},
    {3'b010, 2'd0, 24'h55AA55}, {3'b111, 2'd3, 24'hC0FFEE}
  };

  logic clk = 0, rstN = 0, regWrEn = 0, regSel = 0, pixValidIn = 0;
  logic [15:0] regWdata = '0;
  logic [2:0]  chEnable = '0;
  logic [1:0]  pixChIn = '0;
  logic [23:0] pixIn = '0;
  logic        pixValidOut;
  logic [1:0]  pixChOut;
  logic [23:0] pixOut;

  int checks = 0, failures = 0;
  bit done = 0;
  int mm [TOTAL];
  bit mv [TOTAL];
  int mAddr = 0;
  bit mInc = 0;

  always #5 clk = ~clk;

  gamma_lut dut_i (.*);

  function automatic int fillVal(int a);
    return (a * 7 + (a / 256) * 13 + 3) & 255;
  endfunction

  function automatic logic [23:0] modelPix(logic [2:0] en, logic [1:0] ch, logic [23:0] p);
    logic [23:0] r;
    if (ch > 2 || !en[ch]) return p;
    for (int k = 0; k < 3; k++) begin
      int idx = int'(ch) * 768 + k * 256 + int'(p[(2-k)*8 +: 8]);
      r[(2-k)*8 +: 8] = mv[idx] ? 8'(mm[idx]) : 8'h00;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setEn(logic [2:0] en);
    @(negedge clk);
    chEnable = en;
    if (en == 0) for (int i = 0; i < TOTAL; i++) mv[i] = 0;
  endtask

  task automatic regWrite(bit sel, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regWdata = d;
    if (!sel) begin
      mAddr = int'(d[11:0]); mInc = d[15];
    end else begin
      if (chEnable != 0 && mAddr < TOTAL) begin
        mm[mAddr] = int'(d[7:0]); mv[mAddr] = 1;
      end
      if (mInc) mAddr = (mAddr >= TOTAL - 1) ? 0 : mAddr + 1;
    end
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic sendPix(logic [1:0] ch, logic [23:0] p, string req);
    logic [23:0] exp;
    exp = modelPix(chEnable, ch, p);
    @(negedge clk);
    pixValidIn = 1; pixChIn = ch; pixIn = p;
    @(negedge clk);
    pixValidIn = 0;
    check(pixValidOut == 0, "R7 early valid", 32'(pixValidOut), 0);
    @(negedge clk);
    check(pixValidOut == 1 && pixChOut == ch, "R7 valid/tag", {pixValidOut, pixChOut}, {1'b1, ch});
    check(pixOut == exp, req, 32'(pixOut), 32'(exp));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) begin mm[i] = 0; mv[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(pixValidOut == 0, "R1 reset valid", 32'(pixValidOut), 0);
    setEn(3'b001);
    sendPix(2'd0, 24'h123456, "R1 invalid after reset");

    // R2 R3 R10: full load from address 0 with auto-increment
    setEn(3'b111);
    regWrite(0, 16'h8000);
    for (int a = 0; a < TOTAL; a++) regWrite(1, 16'(fillVal(a)));
    foreach (VEC[i]) begin
      setEn(VEC[i][28:26]);
      sendPix(VEC[i][25:24], VEC[i][23:0], "R2 R6 table vector");
    end
    setEn(3'b111);
    // R5: address wrapped to 0 after the full burst
    regWrite(1, 16'h00C3);
    sendPix(2'd0, 24'h000000, "R5 wrap after burst");
    regWrite(0, 16'h8000 | 16'd2303);
    regWrite(1, 16'h00A5);
    regWrite(1, 16'h005A);
    sendPix(2'd2, 24'h0000FF, "R5 last entry");
    sendPix(2'd0, 24'h000000, "R5 entry zero");
    // R4: fixed address overwrite
    regWrite(0, 16'(768 + 10));
    regWrite(1, 16'h0011);
    regWrite(1, 16'h0022);
    sendPix(2'd1, 24'h0A0B0B, "R4 overwrite");
    sendPix(2'd1, 24'h0B0A0A, "R4 neighbour");
    // R6: disabled channel and out-of-range tag
    setEn(3'b011);
    sendPix(2'd2, 24'h123456, "R6 bypass disabled");
    sendPix(2'd3, 24'hFEDCBA, "R6 bypass tag 3");
    // R8: all off invalidates
    setEn(3'b000);
    @(negedge clk);
    setEn(3'b010);
    sendPix(2'd1, 24'h0A0B0C, "R8 invalid after all off");
    // R9: writes while all off are dropped, address still advances
    setEn(3'b000);
    regWrite(0, 16'h8000 | 16'd768);
    regWrite(1, 16'h0077);
    regWrite(1, 16'h0077);
    setEn(3'b010);
    regWrite(1, 16'h0066);
    sendPix(2'd1, 24'h000000, "R9 dropped write");
    sendPix(2'd1, 24'h020000, "R9 advanced address");
    regWrite(0, 16'h8000 | 16'd768);
    regWrite(1, 16'h0044);
    sendPix(2'd1, 24'h000000, "R8 rewrite valid");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule